// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This controller paces an analog-to-digital converter through a programmable list of channel and gain entries. It holds only the position in the list and the pacing. The entries themselves, the converter, the data path and the sample buffering belong to neighbouring blocks. Those blocks read `list_idx` whenever `conv_strobe` is high. Each pulse of the sample clock (`smp_tick`) while scanning yields one conversion, so each list entry is sampled at the tick rate divided by the list length.

Two modes are offered. In continuous mode an external start trigger begins scanning at entry 0, and the list wraps and repeats without a break. In burst mode every trigger, and every internal retrigger, scans the whole list a programmed number of times (1 to 256). The block then waits for the next retrigger. A 24-bit down counter on the system clock produces that retrigger. Either mode ends when the programmed number of conversions is reached or when a stop is requested. A trigger-status output shows whether the block is waiting for a trigger.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset and while idle, `trig_wait` is 1, `conv_strobe` is 0, `done` is 0 and `list_idx` is 0.
- R2: While scanning, each cycle with `smp_tick` high produces exactly one `conv_strobe` in that same cycle. The first strobe after a trigger is at index 0, and the index rises by one after each strobe.
- R3: After the strobe at entry L-1, where L is the effective list length, the index returns to 0. In continuous mode scanning then carries on without a gap.
- R4: A list length of 0, a scans-per-trigger of 0 or a retrigger period of 0 acts as 1. Length values above 1024 act as 1024, and scan counts above 256 act as 256.
- R5: In burst mode each trigger or retrigger produces exactly L×S strobes, where S is the effective scan count. After these the block waits and ignores `smp_tick`.
- R6: The retrigger fires every P clock cycles, where P is the effective period. The first retrigger comes P cycles after the clock edge that accepted the trigger, so with a tick every cycle the bursts begin at cycles k×P after that edge.
- R7: `trig_wait` is low while scanning and high while idle or waiting for a retrigger. In continuous mode it stays low from the trigger until the operation ends.
- R8: With a nonzero total N, the cycle after the N-th strobe shows `done` high for exactly one cycle, `list_idx` at 0 and the block idle. A total of 0 means no limit.
- R9: A stop request in any active cycle suppresses the strobe of that cycle. `done` pulses in the next cycle and the block returns to idle.
- R10: A retrigger that fires during a burst has no effect on the scan and sets the sticky `overrun` output. Only the next accepted initial trigger clears `overrun`.
- R11: A retrigger in the same cycle as the final strobe of a burst starts the next burst at once. That retrigger does not set `overrun`.
- R12: `start_trig` is ignored while the block is scanning or waiting for a retrigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also clocks the retrigger timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | Sample-clock tick, one conversion slot |
| start_trig | input | 1 | External initial trigger, sampled while idle |
| stop_req | input | 1 | Ends the operation |
| burst_mode | input | 1 | 1 selects burst mode, 0 selects continuous mode |
| list_len | input | 11 | Number of list entries |
| scans_per_trig | input | 9 | List passes per trigger in burst mode |
| retrig_period | input | 24 | Retrigger period in clock cycles |
| total_samples | input | 32 | Total conversions; 0 means no limit |
| list_idx | output | 10 | Current list entry |
| conv_strobe | output | 1 | Convert entry `list_idx` in this cycle |
| done | output | 1 | One-cycle pulse when the operation ends |
| trig_wait | output | 1 | High while waiting for a trigger or retrigger |
| overrun | output | 1 | Sticky flag for a retrigger that arrived during a burst |

## Verification
Two things can fall in the same cycle: the retrigger timer expiring and the final strobe of a burst. The bench provokes this by sweeping periods equal to L×S and one and three cycles longer, and it also uses periods shorter than a burst. When the period equals L×S, it checks that strobes never stop, that `trig_wait` never rises and that `overrun` stays clear. When the period is shorter, it checks that the early retrigger leaves the index sequence unchanged, that `overrun` is set, and that the next burst starts only at the following expiry.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int unsigned LIST_MAX = 1024;
  localparam int unsigned SCAN_MAX = 256;
  localparam int unsigned TMR_W    = 24;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SCAN = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_scan_retrig.sv
module adc_scan_retrig #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run_en,
  input  logic [CNT_W-1:0] period,
  output logic             fire
);

  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // a period of zero behaves as one cycle
  assign reload_val = (period == '0) ? '0 : period - CNT_W'(1);

  assign fire = run_en && (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = reload_val;
    end else if (run_en) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) cnt_d = reload_val;
      else             cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_scan_index.sv
module adc_scan_index #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned LEN_W = 11,
  parameter int unsigned SCN_W = 9,
  parameter int unsigned LEN_MAX = 1024,
  parameter int unsigned SCN_MAX = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [LEN_W-1:0] list_len,
  input  logic [SCN_W-1:0] scans,
  output logic [IDX_W-1:0] idx,
  output logic             last_entry,
  output logic             burst_end
);

  logic [LEN_W-1:0] len_eff;
  logic [SCN_W-1:0] scn_eff;
  logic [IDX_W-1:0] idx_q,  idx_d;
  logic [SCN_W-1:0] scn_q,  scn_d;
  logic             upd_en;
  logic             last_scan;

  always_comb begin
    if (list_len == '0)                     len_eff = LEN_W'(1);
    else if (list_len > LEN_W'(LEN_MAX))    len_eff = LEN_W'(LEN_MAX);
    else                                    len_eff = list_len;
    if (scans == '0)                        scn_eff = SCN_W'(1);
    else if (scans > SCN_W'(SCN_MAX))       scn_eff = SCN_W'(SCN_MAX);
    else                                    scn_eff = scans;
  end

  assign last_entry = ({1'b0, idx_q} == {1'b0, len_eff - LEN_W'(1)});
  assign last_scan  = (scn_q == scn_eff - SCN_W'(1));
  assign burst_end  = last_entry && last_scan;
  assign idx        = idx_q;

  always_comb begin
    upd_en = clr || adv;
    idx_d  = idx_q;
    scn_d  = scn_q;
    if (clr) begin
      idx_d = '0;
      scn_d = '0;
    end else if (adv) begin
      if (last_entry) begin
        idx_d = '0;
        scn_d = last_scan ? '0 : scn_q + SCN_W'(1);
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      scn_q <= '0;
    end else if (upd_en) begin
      idx_q <= idx_d;
      scn_q <= scn_d;
    end
  end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int unsigned TOT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_tick,
  input  logic             start_trig,
  input  logic             stop_req,
  input  logic             burst_mode,
  input  logic [TOT_W-1:0] total_samples,
  input  logic             tmr_fire,
  input  logic             burst_end,
  output logic             conv_strobe,
  output logic             seq_clr,
  output logic             tmr_load,
  output logic             tmr_run,
  output logic             done,
  output logic             trig_wait,
  output logic             overrun
);

  seq_state_e       st_q, st_d;
  logic [TOT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             ovr_q, ovr_d;
  logic             done_q;
  logic             accept;
  logic             hit_total;
  logic             finish;
  logic             last_of_burst;

  assign conv_strobe   = (st_q == SEQ_SCAN) && smp_tick && !stop_req;
  assign accept        = (st_q == SEQ_IDLE) && start_trig && !stop_req;
  assign hit_total     = conv_strobe && (total_samples != '0) &&
                         (cnt_q + TOT_W'(1) == total_samples);
  assign finish        = (st_q != SEQ_IDLE) && (stop_req || hit_total);
  assign last_of_burst = burst_mode && conv_strobe && burst_end;

  assign seq_clr   = accept || finish;
  assign tmr_load  = accept;
  assign tmr_run   = burst_mode && (st_q != SEQ_IDLE);
  assign trig_wait = (st_q != SEQ_SCAN);
  assign done      = done_q;
  assign overrun   = ovr_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (accept) st_d = SEQ_SCAN;
      SEQ_SCAN: begin
        if (finish)                         st_d = SEQ_IDLE;
        else if (last_of_burst && !tmr_fire) st_d = SEQ_HOLD;
      end
      SEQ_HOLD: begin
        if (finish)        st_d = SEQ_IDLE;
        else if (tmr_fire) st_d = SEQ_SCAN;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (seq_clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (conv_strobe) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + TOT_W'(1);
    end
  end

  always_comb begin
    ovr_d = ovr_q;
    if (accept)
      ovr_d = 1'b0;
    else if ((st_q == SEQ_SCAN) && burst_mode && tmr_fire &&
             !last_of_burst && !finish)
      ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      ovr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ovr_q  <= ovr_d;
      done_q <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned LEN_MAX = LIST_MAX,
  parameter int unsigned SCN_MAX = SCAN_MAX,
  parameter int unsigned PER_W   = TMR_W,
  parameter int unsigned TOT_W   = 32,
  localparam int unsigned IDX_W  = $clog2(LEN_MAX),
  localparam int unsigned LEN_W  = $clog2(LEN_MAX + 1),
  localparam int unsigned SCN_W  = $clog2(SCN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_tick,
  input  logic             start_trig,
  input  logic             stop_req,
  input  logic             burst_mode,
  input  logic [LEN_W-1:0] list_len,
  input  logic [SCN_W-1:0] scans_per_trig,
  input  logic [PER_W-1:0] retrig_period,
  input  logic [TOT_W-1:0] total_samples,
  output logic [IDX_W-1:0] list_idx,
  output logic             conv_strobe,
  output logic             done,
  output logic             trig_wait,
  output logic             overrun
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       seq_clr;
  logic       tmr_load;
  logic       tmr_run;
  logic       tmr_fire;
  logic       last_entry;
  logic       burst_end;
  logic       strobe_int;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  adc_scan_fsm #(.TOT_W(TOT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .smp_tick      (smp_tick),
    .start_trig    (start_trig),
    .stop_req      (stop_req),
    .burst_mode    (burst_mode),
    .total_samples (total_samples),
    .tmr_fire      (tmr_fire),
    .burst_end     (burst_end),
    .conv_strobe   (strobe_int),
    .seq_clr       (seq_clr),
    .tmr_load      (tmr_load),
    .tmr_run       (tmr_run),
    .done          (done),
    .trig_wait     (trig_wait),
    .overrun       (overrun)
  );

  adc_scan_index #(
    .IDX_W   (IDX_W),
    .LEN_W   (LEN_W),
    .SCN_W   (SCN_W),
    .LEN_MAX (LEN_MAX),
    .SCN_MAX (SCN_MAX)
  ) u_index (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clr        (seq_clr),
    .adv        (strobe_int),
    .list_len   (list_len),
    .scans      (scans_per_trig),
    .idx        (list_idx),
    .last_entry (last_entry),
    .burst_end  (burst_end)
  );

  adc_scan_retrig #(.CNT_W(PER_W)) u_retrig (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load   (tmr_load),
    .run_en (tmr_run),
    .period (retrig_period),
    .fire   (tmr_fire)
  );

  assign conv_strobe = strobe_int;

  // last_entry is also decoded inside the index block for burst_end
  logic unused_ok;
  assign unused_ok = last_entry;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned LEN_MAX = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             start_trig,
  input logic [LEN_W-1:0] list_len,
  input logic [IDX_W-1:0] list_idx,
  input logic             conv_strobe,
  input logic             done,
  input logic             trig_wait,
  input logic             overrun
);

  int unsigned len_eff;
  always_comb begin
    if (list_len == '0)                   len_eff = 1;
    else if (int'(list_len) > LEN_MAX)    len_eff = LEN_MAX;
    else                                  len_eff = int'(list_len);
  end

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(list_idx) < len_eff);

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && (int'(list_idx) + 1 < len_eff)) |=>
      (done || (int'(list_idx) == int'($past(list_idx)) + 1)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (list_idx == '0 && trig_wait && !conv_strobe));

  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !trig_wait) |=> done);

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !start_trig) |=> overrun);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .IDX_W   (IDX_W),
  .LEN_W   (LEN_W),
  .LEN_MAX (LEN_MAX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_req    (stop_req),
  .start_trig  (start_trig),
  .list_len    (list_len),
  .list_idx    (list_idx),
  .conv_strobe (conv_strobe),
  .done        (done),
  .trig_wait   (trig_wait),
  .overrun     (overrun)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        smp_tick;
  logic        start_trig;
  logic        stop_req;
  logic        burst_mode;
  logic [10:0] list_len;
  logic [8:0]  scans_per_trig;
  logic [23:0] retrig_period;
  logic [31:0] total_samples;
  logic [9:0]  list_idx;
  logic        conv_strobe;
  logic        done;
  logic        trig_wait;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  adc_scan_seq u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .smp_tick       (smp_tick),
    .start_trig     (start_trig),
    .stop_req       (stop_req),
    .burst_mode     (burst_mode),
    .list_len       (list_len),
    .scans_per_trig (scans_per_trig),
    .retrig_period  (retrig_period),
    .total_samples  (total_samples),
    .list_idx       (list_idx),
    .conv_strobe    (conv_strobe),
    .done           (done),
    .trig_wait      (trig_wait),
    .overrun        (overrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int v, input int mx);
    if (v == 0) return 1;
    if (v > mx) return mx;
    return v;
  endfunction

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // checks the done pulse and idle state after the ending interval
  task automatic check_end(input string req);
    @(negedge clk);
    start_trig = 0; stop_req = 0; smp_tick = 0;
    #1;
    chk(req, "done pulse", done, 1);
    chk(req, "index cleared", list_idx, 0);
    chk("R7", "waiting after end", trig_wait, 1);
    @(negedge clk); #1;
    chk(req, "done single cycle", done, 0);
  endtask

  task automatic run_case(input bit bm, input int l, input int s, input int p,
                          input int n, input int d, input int stop_at,
                          input int ext_at);
    int le, se, pe, b, k, ph;
    bit fin, stb_e, tw_e;
    int idx_e;
    le = eff(l, 1024); se = eff(s, 256); pe = (p == 0) ? 1 : p; b = le * se;
    @(negedge clk);
    burst_mode = bm; list_len = 11'(l); scans_per_trig = 9'(s);
    retrig_period = 24'(p); total_samples = 32'(n);
    smp_tick = 0; stop_req = 0; start_trig = 1;
    #1;
    chk("R1", "idle waiting before trigger", trig_wait, 1);
    chk("R1", "idle no strobe", conv_strobe, 0);
    k = 0; fin = 0;
    for (int c = 0; c < 5000 && !fin; c++) begin
      @(negedge clk);
      start_trig = (c == ext_at);
      smp_tick   = bm ? 1'b1 : ((c % d) == 0);
      stop_req   = (c == stop_at);
      #1;
      if (bm) begin
        ph    = c % pe;
        stb_e = (ph < b);
        idx_e = stb_e ? (ph % le) : 0;
        tw_e  = !stb_e;
      end else begin
        stb_e = smp_tick;
        idx_e = k % le;
        tw_e  = 0;
      end
      if (stop_req) stb_e = 0;
      // R5 R6 R11 in burst mode, R2 R3 R12 in continuous mode
      chk(bm ? "R5" : "R2", "strobe", conv_strobe, stb_e);
      chk(bm ? "R6" : "R3", "index", list_idx, idx_e);
      chk("R7", "trigger status", trig_wait, stop_req ? trig_wait : tw_e);
      if (bm && b == pe) chk("R11", "no overrun on coincident retrigger", overrun, 0);
      if (stb_e) k++;
      if (stop_req || (n != 0 && k == n)) fin = 1;
    end
    check_end(stop_at >= 0 ? "R9" : "R8");
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; smp_tick = 0; start_trig = 0; stop_req = 0; burst_mode = 0;
    list_len = 4; scans_per_trig = 1; retrig_period = 8; total_samples = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset trig_wait", trig_wait, 1);
    chk("R1", "reset strobe", conv_strobe, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset index", list_idx, 0);
    chk("R10", "reset overrun", overrun, 0);

    // continuous sweep: lengths incl. zero, totals, tick spacing (R2 R3 R4 R8)
    for (int l = 0; l <= 5; l++)
      for (int ni = 0; ni < 3; ni++)
        for (int d = 1; d <= 3; d++)
          run_case(0, l, 1, 1, (ni == 0) ? 1 : (ni == 1 ? 4 : 9), d, -1, -1);

    // burst sweep: period equal to, one above and three above L*S (R5 R6 R11)
    for (int l = 1; l <= 3; l++)
      for (int s = 1; s <= 3; s++)
        for (int pi = 0; pi < 3; pi++)
          run_case(1, l, s, l * s + (pi == 0 ? 0 : (pi == 1 ? 1 : 3)),
                   2 * l * s + 1, 1, -1, -1);

    // R4 zero scan count and zero period act as one
    run_case(1, 0, 0, 0, 5, 1, -1, -1);
    run_case(1, 2, 0, 4, 5, 1, -1, -1);
    // R9 stop in continuous scan and in burst wait, unlimited total
    run_case(0, 3, 1, 1, 0, 1, 7, -1);
    run_case(1, 2, 1, 5, 0, 1, 3, -1);
    // R12 start trigger while active is ignored
    run_case(0, 3, 1, 1, 8, 1, -1, 2);
    run_case(1, 2, 1, 5, 6, 1, -1, 3);

    // R10 retrigger during a burst: L=3 S=2 P=4
    @(negedge clk);
    burst_mode = 1; list_len = 3; scans_per_trig = 2; retrig_period = 4;
    total_samples = 0; smp_tick = 1; start_trig = 1; stop_req = 0;
    for (int c = 0; c <= 8; c++) begin
      @(negedge clk);
      start_trig = 0;
      #1;
      if (c <= 5) begin
        chk("R10", "burst continues over early retrigger", conv_strobe, 1);
        chk("R10", "index unaffected", list_idx, c % 3);
      end
      if (c == 3) chk("R10", "overrun before early retrigger", overrun, 0);
      if (c == 4) chk("R10", "overrun set", overrun, 1);
      if (c == 6 || c == 7) chk("R10", "held until next expiry", conv_strobe, 0);
      if (c == 8) begin
        chk("R10", "next burst at following expiry", conv_strobe, 1);
        chk("R10", "next burst index", list_idx, 0);
        chk("R10", "overrun sticky", overrun, 1);
      end
    end
    @(negedge clk);
    stop_req = 1;
    check_end("R9");
    // new initial trigger clears overrun
    @(negedge clk);
    burst_mode = 0; start_trig = 1;
    @(negedge clk);
    start_trig = 0;
    #1;
    chk("R10", "overrun cleared by new trigger", overrun, 0);
    @(negedge clk);
    stop_req = 1;
    check_end("R9");

    finish_run();
  end

endmodule